// File: doc/BRIEF.md
# Four-Bank Interleaved Scratchpad with Port Crossbar

This block is a word-addressed scratchpad memory built from four single-ported banks. Four requesters share it. Ports 0 to 2 serve the compute DMA channels and port 3 serves the IO DMA. The two lowest address bits pick the bank, and the remaining upper bits pick the row inside that bank. A crossbar connects each requester to its bank. Requests that fall in different banks all proceed in the same cycle.

Each bank has its own round-robin arbiter. When more than one port addresses a bank in the same cycle, the arbiter admits exactly one of them. The other ports see a stall and must present the same request again on the next cycle. A grant is combinational within the request cycle. A granted write updates the bank at the next clock edge. A granted read returns its word on the following cycle, on the port that asked for it, with a response strobe.

Each word is 512 bits wide by default, which holds 32 values of 16-bit fixed point. The word width and the number of rows per bank are parameters.

Top module: `scp_xbar`

## Requirements
- R1: Address bits [1:0] select the bank, and bits [ADDR_W-1:2] select the row within that bank. Two addresses that differ in either field refer to distinct words.
- R2: In any cycle, each bank is granted to at most one port.
- R3: A valid port whose bank no other valid port addresses in that cycle is granted in that same cycle.
- R4: Arbitration is round-robin per bank. After reset, port 0 has the highest priority. The search order is port index ascending, wrapping from 3 to 0, starting just after the port that last won that bank. A port therefore never wins a bank twice in a row while another port is requesting it.
- R5: `req_grant` is only ever high for a valid port. `req_stall` is high exactly when a port is valid and not granted.
- R6: A granted write stores `req_wdata` into the addressed word at the next clock edge. A write that is stalled leaves memory unchanged.
- R7: A granted read raises `rsp_valid` on that port one cycle later, and `rsp_rdata` then holds the word as it stood at the grant cycle. `rsp_valid` is low in every other case.
- R8: While reset is asserted, and with no requests present, `rsp_valid` and `req_grant` are low. Reset also returns every arbiter to port-0 priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_PORTS | Request present, per port (port 3 is the IO DMA) |
| req_we | input | NUM_PORTS | 1 = write, 0 = read, per port |
| req_addr | input | NUM_PORTS x ADDR_W | Word address per port; bits [1:0] give the bank |
| req_wdata | input | NUM_PORTS x DATA_W | Write data per port |
| req_grant | output | NUM_PORTS | Request accepted this cycle |
| req_stall | output | NUM_PORTS | Request blocked by a bank conflict; hold it |
| rsp_valid | output | NUM_PORTS | Read data valid (one cycle after the grant) |
| rsp_rdata | output | NUM_PORTS x DATA_W | Read data routed back to the requesting port |

## Verification
The bench's main target is full contention, where all four ports address the same bank. A design with a broken rotation pointer would grant one port repeatedly and starve the others, or it would grant two ports at once. The bench also mixes partial collisions with conflict-free cycles. A crossbar that serialised independent banks would stall a port that should have been granted. Random reads are compared with a flat model of memory, which exposes three kinds of fault: a mis-decoded bank or row field, a stalled write that leaked into memory, and read data routed back to the wrong port or in the wrong cycle.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int BANK_SEL_W = 2;
  localparam int NUM_BANKS  = 1 << BANK_SEL_W;
endpackage

// File: rtl/scp_rr_arb.sv
module scp_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             any_gnt;
  logic             arm_q;

  always_comb begin
    int idx;
    logic [PTR_W-1:0] win;
    gnt     = '0;
    any_gnt = 1'b0;
    win     = '0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!any_gnt && req[idx]) begin
        any_gnt  = 1'b1;
        gnt[idx] = 1'b1;
        win      = PTR_W'(idx);
      end
    end
    ptr_d = ptr_q;
    if (any_gnt) ptr_d = PTR_W'((int'(win) + 1) % N);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      arm_q <= 1'b0;
    end else begin
      arm_q <= 1'b1;
      if (any_gnt) ptr_q <= ptr_d;
    end
  end

  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R2
  AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R5
  AST_RR_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && gnt != '0 && gnt == $past(gnt)) |-> (req == gnt)); // R4
endmodule

// File: rtl/scp_bank.sv
module scp_bank #(
  parameter int DATA_W = 512,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] mem [ROWS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    rdata_q  <= mem[row];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/scp_xbar.sv
module scp_xbar #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 512,
  parameter int ROW_W     = 4,
  localparam int SEL_W    = scp_pkg::BANK_SEL_W,
  localparam int NB       = scp_pkg::NUM_BANKS,
  localparam int ADDR_W   = SEL_W + ROW_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0]              req_valid,
  input  logic [NUM_PORTS-1:0]              req_we,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  req_addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  req_wdata,
  output logic [NUM_PORTS-1:0]              req_grant,
  output logic [NUM_PORTS-1:0]              req_stall,
  output logic [NUM_PORTS-1:0]              rsp_valid,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rsp_rdata
);
  logic [NB-1:0][NUM_PORTS-1:0] bk_req;
  logic [NB-1:0][NUM_PORTS-1:0] bk_gnt;
  logic [NB-1:0]                bk_en;
  logic [NB-1:0]                bk_we;
  logic [NB-1:0][ROW_W-1:0]     bk_row;
  logic [DATA_W-1:0]            bk_wdata [NB];
  logic [DATA_W-1:0]            bk_rdata [NB];

  logic [NUM_PORTS-1:0]            rsp_valid_q, rsp_valid_d;
  logic [NUM_PORTS-1:0][SEL_W-1:0] rsp_bank_q,  rsp_bank_d;
  logic [NUM_PORTS-1:0]            rsp_bank_en;

  // request steering by low address bits
  always_comb begin
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < NUM_PORTS; p++)
        bk_req[b][p] = req_valid[p] && (req_addr[p][SEL_W-1:0] == SEL_W'(b));
  end

  // bank side multiplexers
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      bk_en[b]    = |bk_gnt[b];
      bk_we[b]    = 1'b0;
      bk_row[b]   = '0;
      bk_wdata[b] = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (bk_gnt[b][p]) begin
          bk_we[b]    = req_we[p];
          bk_row[b]   = req_addr[p][ADDR_W-1:SEL_W];
          bk_wdata[b] = req_wdata[p];
        end
      end
    end
  end

  for (genvar gb = 0; gb < NB; gb++) begin : g_bank
    scp_rr_arb #(.N(NUM_PORTS)) i_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (bk_req[gb]),
      .gnt   (bk_gnt[gb])
    );
    scp_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) i_bank (
      .clk   (clk),
      .en    (bk_en[gb]),
      .we    (bk_we[gb]),
      .row   (bk_row[gb]),
      .wdata (bk_wdata[gb]),
      .rdata (bk_rdata[gb])
    );
  end

  // port side grant and stall
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      req_grant[p] = 1'b0;
      for (int b = 0; b < NB; b++)
        req_grant[p] = req_grant[p] | bk_gnt[b][p];
      req_stall[p] = req_valid[p] & ~req_grant[p];
    end
  end

  // response tracking: next state
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      rsp_valid_d[p] = req_grant[p] & ~req_we[p];
      rsp_bank_en[p] = req_grant[p] & ~req_we[p];
      rsp_bank_d[p]  = req_addr[p][SEL_W-1:0];
    end
  end

  // response tracking: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= '0;
      rsp_bank_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      for (int p = 0; p < NUM_PORTS; p++)
        if (rsp_bank_en[p]) rsp_bank_q[p] <= rsp_bank_d[p];
    end
  end

  // return path
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++)
      rsp_rdata[p] = bk_rdata[rsp_bank_q[p]];
  end
  assign rsp_valid = rsp_valid_q;

  // checker support: ports alone on their bank this cycle
  logic [NUM_PORTS-1:0] shared_bank;
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      shared_bank[p] = 1'b0;
      for (int q = 0; q < NUM_PORTS; q++)
        if (q != p && req_valid[q] &&
            req_addr[q][SEL_W-1:0] == req_addr[p][SEL_W-1:0])
          shared_bank[p] = 1'b1;
    end
  end

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_chk
    AST_ALONE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[gp] && !shared_bank[gp]) |-> req_grant[gp]); // R3
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[gp] |-> $past(req_valid[gp] && !req_we[gp])); // R7
  end
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0); // R5
endmodule

// File: tb/test_scp_xbar.sv
module test_scp_xbar;
  localparam int NP     = 4;
  localparam int DATA_W = 512;
  localparam int ROW_W  = 4;
  localparam int ADDR_W = 2 + ROW_W;
  localparam int WORDS  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0]             req_valid;
  logic [NP-1:0]             req_we;
  logic [NP-1:0][ADDR_W-1:0] req_addr;
  logic [NP-1:0][DATA_W-1:0] req_wdata;
  logic [NP-1:0]             req_grant;
  logic [NP-1:0]             req_stall;
  logic [NP-1:0]             rsp_valid;
  logic [NP-1:0][DATA_W-1:0] rsp_rdata;

  always #5 clk = ~clk;

  scp_xbar #(.NUM_PORTS(NP), .DATA_W(DATA_W), .ROW_W(ROW_W)) i_scp_xbar (
    .clk, .rst_n, .req_valid, .req_we, .req_addr, .req_wdata,
    .req_grant, .req_stall, .rsp_valid, .rsp_rdata
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [DATA_W-1:0] ref_mem [WORDS];
  int                ref_ptr [4];
  logic [NP-1:0]     exp_rv;
  logic [DATA_W-1:0] exp_rd [NP];
  logic [NP-1:0]     last_stall;
  int                win_cnt [NP];

  task automatic chk(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  function automatic logic [DATA_W-1:0] rand_word();
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W / 32; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  function automatic logic [NP-1:0] model_grant();
    logic [NP-1:0] g = '0;
    for (int b = 0; b < 4; b++) begin
      bit found = 0;
      for (int k = 0; k < NP; k++) begin
        int idx = (ref_ptr[b] + k) % NP;
        if (!found && req_valid[idx] && req_addr[idx][1:0] == 2'(b)) begin
          found  = 1;
          g[idx] = 1'b1;
        end
      end
    end
    return g;
  endfunction

  // one clock cycle: inputs already driven after a negedge
  task automatic cycle();
    logic [NP-1:0] eg;
    #1;
    eg = model_grant();
    chk(req_grant == eg, "R3",
        $sformatf("R4 grant act %b exp %b", req_grant, eg));
    chk(req_stall == (req_valid & ~eg), "R5",
        $sformatf("stall act %b exp %b", req_stall, req_valid & ~eg));
    for (int p = 0; p < NP; p++) begin
      chk(rsp_valid[p] == exp_rv[p], "R7",
          $sformatf("port %0d rsp_valid act %b exp %b", p, rsp_valid[p], exp_rv[p]));
      if (exp_rv[p])
        chk(rsp_rdata[p] == exp_rd[p], "R1",
            $sformatf("R6 port %0d rdata act %h exp %h", p, rsp_rdata[p][63:0], exp_rd[p][63:0]));
    end
    exp_rv = '0;
    for (int p = 0; p < NP; p++) begin
      if (eg[p]) begin
        win_cnt[p]++;
        ref_ptr[req_addr[p][1:0]] = (p + 1) % NP;
        if (req_we[p]) ref_mem[req_addr[p]] = req_wdata[p];
        else begin
          exp_rv[p] = 1'b1;
          exp_rd[p] = ref_mem[req_addr[p]];
        end
      end
    end
    last_stall = req_valid & ~eg;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5c7a_0042));
    rst_n = 1'b0;
    req_valid = '0; req_we = '0; req_addr = '0; req_wdata = '0;
    exp_rv = '0; last_stall = '0;
    for (int b = 0; b < 4; b++) ref_ptr[b] = 0;
    for (int p = 0; p < NP; p++) win_cnt[p] = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == '0, "R8", $sformatf("rsp_valid in reset act %b exp 0", rsp_valid));
    chk(req_grant == '0, "R8", $sformatf("grant in reset act %b exp 0", req_grant));
    rst_n = 1'b1;
    @(negedge clk);

    // fill memory: port p writes bank p, all granted together
    for (int r = 0; r < (1 << ROW_W); r++) begin
      for (int p = 0; p < NP; p++) begin
        req_valid[p] = 1'b1;
        req_we[p]    = 1'b1;
        req_addr[p]  = {ROW_W'(r), 2'(p)};
        req_wdata[p] = rand_word();
      end
      cycle();
      chk(last_stall == '0, "R3", $sformatf("fill stall act %b exp 0", last_stall));
    end

    // full contention on bank 2, reads held while stalled
    for (int p = 0; p < NP; p++) begin
      win_cnt[p]   = 0;
      req_valid[p] = 1'b1;
      req_we[p]    = 1'b0;
      req_addr[p]  = {ROW_W'(p + 3), 2'd2};
    end
    for (int c = 0; c < 8; c++) cycle();
    for (int p = 0; p < NP; p++)
      chk(win_cnt[p] == 2, "R4",
          $sformatf("port %0d wins act %0d exp 2", p, win_cnt[p]));

    // stalled write vs read of same word: reads must see only granted writes
    for (int c = 0; c < 6; c++) begin
      for (int p = 0; p < NP; p++) begin
        req_valid[p] = 1'b1;
        req_we[p]    = (p % 2 == 0);
        req_addr[p]  = {ROW_W'(5), 2'd1};
        req_wdata[p] = rand_word();
      end
      cycle();
    end

    // constrained random traffic
    for (int c = 0; c < 3000; c++) begin
      bit hot = ($urandom % 4) == 0;
      logic [1:0] hb = 2'($urandom);
      for (int p = 0; p < NP; p++) begin
        if (!last_stall[p]) begin
          req_valid[p] = ($urandom % 4) != 0;
          req_we[p]    = $urandom % 2;
          req_addr[p]  = ADDR_W'($urandom);
          if (hot) req_addr[p][1:0] = hb;
          req_wdata[p] = rand_word();
        end
      end
      cycle();
    end

    req_valid = '0;
    cycle();
    cycle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule